// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block decides where each CPU memory access into the legacy area from 0xA0000 to 0xFFFFF goes. It can go to system DRAM, or it can be forwarded to the PCI/ISA bus. A write can also be dropped when the target area is read-only. The decision depends on a set of 2-bit attribute fields, one per 16 KB expansion segment plus one for the 64 KB top segment, and on a window control byte for the 0xA0000-0xBFFFF video/system-management area.

Configuration writes arrive on a simple byte write port with an 8-bit offset. Only offsets 0x59-0x5F (attribute bytes) and 0x72 (window control) are decoded. The route decision is purely combinational from the request address, the request direction, the stored registers and the SMM-active input. So any register update is in force for the first access after the clock edge that captured it, and any change of SMM-active is in force at once.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset the window control byte is 0x02 and every attribute field is 0. So reads and writes to the whole region 0xA0000-0xFFFFF are forwarded to the bus.
- R2: Accesses to 0xF0000-0xFFFFF use the 2-bit attribute in bits 5:4 of offset 0x59.
- R3: Segment i (0..11) covers 0xC0000 + i*0x4000 up to 16 KB. It uses offset 0x5A + i/2, in bits 1:0 for even i and bits 5:4 for odd i. Bits 3:2 and 7:6 of attribute bytes have no effect.
- R4: Attribute bit 0 sends reads to DRAM (else bus) and attribute bit 1 sends writes to DRAM. So 3 means DRAM for both, 2 means read forwarded and write to DRAM, and 0 forwards both.
- R5: A write under attribute 1 raises route_drop_o. Exactly one of route_dram_o, route_bus_o, route_drop_o is high at all times, and a drop only ever happens on a write.
- R6: With bit 6 of offset 0x72 set, reads and writes to 0xA0000-0xBFFFF go to DRAM. With the window closed they are forwarded to the bus.
- R7: When smm_active_i is high and bit 3 of offset 0x72 is set, the window 0xA0000-0xBFFFF goes to DRAM, and a change of smm_active_i acts on the same cycle's decision.
- R8: Bit 4 of offset 0x72 is a lock. A write that sets it forces bit 6 to 0. While it is set, later writes cannot set bit 6 or clear bit 4, but bit 3 stays writable. Only reset clears the lock.
- R9: Addresses below 0xA0000 or at or above 0x100000 always go to DRAM, whatever the registers hold.
- R10: A configuration write is in force for the access decoded after the capturing clock edge. Writes to any offset other than 0x59-0x5F and 0x72 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| smm_active_i | input | 1 | System-management mode active |
| req_addr_i | input | 32 | Memory request byte address |
| req_we_i | input | 1 | Request is a write (1) or read (0) |
| route_dram_o | output | 1 | Access goes to DRAM |
| route_bus_o | output | 1 | Access is forwarded to the PCI/ISA bus |
| route_drop_o | output | 1 | Write to read-only area, discarded |

## Verification
The bench writes all four attribute values into every segment in rotating patterns, with junk in the unused nibble bits, and probes the first and last byte of each segment. A swapped nibble, an off-by-one byte offset or a wrong segment boundary would then route some segment by its neighbour's field. It sweeps every combination of open bit, SMM-enable bit and SMM input over the window, so a design that ignores the input or ORs the wrong bits sends the window to the wrong target. The lock sequence checks that bit 6 cannot reopen the window after locking, that the SMM path still works, and that only reset releases it. Probes just outside both ends of the legacy range catch comparisons that are off by one.

// File: rtl/legacy_dec_pkg.sv
`timescale 1ns/1ps
package legacy_dec_pkg;

  localparam int unsigned SMR_SMM_EN_BIT = 3;
  localparam int unsigned SMR_LOCK_BIT   = 4;
  localparam int unsigned SMR_OPEN_BIT   = 6;

  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'd0,
    ROUTE_BUS  = 2'd1,
    ROUTE_DROP = 2'd2
  } route_e;

  // bit0: reads to DRAM, bit1: writes to DRAM
  function automatic route_e attr_route(input logic [1:0] attr, input logic is_write);
    if (!is_write) return attr[0] ? ROUTE_DRAM : ROUTE_BUS;
    if (attr[1]) return ROUTE_DRAM;
    return (attr == 2'd1) ? ROUTE_DROP : ROUTE_BUS;
  endfunction

endpackage

// File: rtl/lmd_cfg_regs.sv
`timescale 1ns/1ps
module lmd_cfg_regs
  import legacy_dec_pkg::*;
#(
  parameter int unsigned CFG_AW    = 8,
  parameter int unsigned NUM_PAM   = 7,
  parameter int unsigned PAM_BASE  = 'h59,
  parameter int unsigned SMR_OFF   = 'h72,
  parameter logic [7:0]  SMR_RESET = 8'h02
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [7:0]           cfg_wdata_i,
  output logic [NUM_PAM*8-1:0] pam_o,
  output logic [7:0]           smram_o
);

  localparam logic [CFG_AW-1:0] SMR_ADDR = CFG_AW'(SMR_OFF);

  for (genvar gi = 0; gi < NUM_PAM; gi++) begin : g_pam
    localparam logic [CFG_AW-1:0] OFF = CFG_AW'(PAM_BASE + gi);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (cfg_we_i && cfg_addr_i == OFF) q <= cfg_wdata_i;
    end
    assign pam_o[gi*8 +: 8] = q;
  end

  logic [7:0] smr_q, smr_d;

  always_comb begin
    smr_d = cfg_wdata_i;
    if (smr_q[SMR_LOCK_BIT]) begin
      smr_d[SMR_LOCK_BIT] = 1'b1;
      smr_d[SMR_OPEN_BIT] = 1'b0;
    end else if (cfg_wdata_i[SMR_LOCK_BIT]) begin
      smr_d[SMR_OPEN_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               smr_q <= SMR_RESET;
    else if (cfg_we_i && cfg_addr_i == SMR_ADDR) smr_q <= smr_d;
  end

  assign smram_o = smr_q;

endmodule

// File: rtl/lmd_attr_select.sv
`timescale 1ns/1ps
module lmd_attr_select #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_COUNT = 12,
  parameter int unsigned SEG_SHIFT = 14,
  parameter int unsigned EXP_BASE  = 'hC0000,
  parameter int unsigned NUM_PAM   = 7
) (
  input  logic [NUM_PAM*8-1:0] pam_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 in_range_o,
  output logic [1:0]           attr_o
);

  localparam int unsigned IDX_W   = $clog2(SEG_COUNT + 1);
  localparam int unsigned SEG_SZ  = 1 << SEG_SHIFT;
  localparam int unsigned TOP_END = EXP_BASE + SEG_COUNT * SEG_SZ + 4 * SEG_SZ;
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(EXP_BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(TOP_END);

  logic [1:0] seg_attr [SEG_COUNT+1];
  logic [NUM_PAM*8-1:0] used_mask;

  for (genvar gi = 0; gi < SEG_COUNT; gi++) begin : g_seg
    localparam int unsigned POS = (1 + gi / 2) * 8 + (gi % 2) * 4;
    assign seg_attr[gi] = pam_i[POS +: 2];
    assign used_mask[POS +: 2] = 2'b11;
    assign used_mask[POS + 2 +: 2] = 2'b00;
  end
  if (SEG_COUNT % 2 == 1) begin : g_odd_tail
    assign used_mask[NUM_PAM*8-4 +: 4] = 4'b0000;
  end
  assign seg_attr[SEG_COUNT] = pam_i[4 +: 2];  // top 64 KB segment
  assign used_mask[7:0] = 8'b0011_0000;

  logic unused_pam_bits;
  assign unused_pam_bits = ^(pam_i & ~used_mask);

  logic [ADDR_W-1:0] offset, idx_raw;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    in_range_o = (addr_i >= LO) && (addr_i < HI);
    offset     = addr_i - LO;
    idx_raw    = offset >> SEG_SHIFT;
    idx        = (idx_raw >= ADDR_W'(SEG_COUNT)) ? IDX_W'(SEG_COUNT) : idx_raw[IDX_W-1:0];
    attr_o     = seg_attr[idx];
  end

endmodule

// File: rtl/legacy_mem_decoder.sv
`timescale 1ns/1ps
module legacy_mem_decoder
  import legacy_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_COUNT = 12,
  parameter int unsigned SEG_SHIFT = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              smm_active_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  output logic              route_dram_o,
  output logic              route_bus_o,
  output logic              route_drop_o
);

  localparam int unsigned NUM_PAM  = 1 + (SEG_COUNT + 1) / 2;
  localparam int unsigned WIN_BASE = 'hA0000;
  localparam int unsigned EXP_BASE = 'hC0000;
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(EXP_BASE);

  logic [NUM_PAM*8-1:0] pam_q;
  logic [7:0]           smram_q;
  logic                 in_pam;
  logic [1:0]           seg_attr;

  lmd_cfg_regs #(
    .CFG_AW (8),
    .NUM_PAM(NUM_PAM)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .pam_o      (pam_q),
    .smram_o    (smram_q)
  );

  lmd_attr_select #(
    .ADDR_W   (ADDR_W),
    .SEG_COUNT(SEG_COUNT),
    .SEG_SHIFT(SEG_SHIFT),
    .EXP_BASE (EXP_BASE),
    .NUM_PAM  (NUM_PAM)
  ) i_sel (
    .pam_i     (pam_q),
    .addr_i    (req_addr_i),
    .in_range_o(in_pam),
    .attr_o    (seg_attr)
  );

  logic   in_win, win_open;
  route_e route;

  logic unused_smram;
  assign unused_smram = ^{smram_q[7], smram_q[5], smram_q[2:0]};

  always_comb begin
    in_win   = (req_addr_i >= WIN_LO) && (req_addr_i < WIN_HI);
    win_open = smram_q[SMR_OPEN_BIT] | (smm_active_i & smram_q[SMR_SMM_EN_BIT]);
    if (in_win)      route = win_open ? ROUTE_DRAM : ROUTE_BUS;
    else if (in_pam) route = attr_route(seg_attr, req_we_i);
    else             route = ROUTE_DRAM;
  end

  assign route_dram_o = (route == ROUTE_DRAM);
  assign route_bus_o  = (route == ROUTE_BUS);
  assign route_drop_o = (route == ROUTE_DROP);

endmodule

// File: rtl/lmd_checker.sv
`timescale 1ns/1ps
module lmd_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smm_active_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_we_i,
  input logic              route_dram_o,
  input logic              route_bus_o,
  input logic              route_drop_o,
  input logic [7:0]        smram_q
);

  logic outside, in_win;
  assign outside = (req_addr_i < ADDR_W'(32'hA0000)) || (req_addr_i >= ADDR_W'(32'h100000));
  assign in_win  = (req_addr_i >= ADDR_W'(32'hA0000)) && (req_addr_i < ADDR_W'(32'hC0000));

  p_one_route_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({route_dram_o, route_bus_o, route_drop_o}) == 1);

  p_drop_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_drop_o |-> req_we_i);

  p_outside_dram_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outside |-> route_dram_o);

  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(smram_q[4]) |-> smram_q[4]);

  p_lock_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smram_q[4] |-> !smram_q[6]);

  p_open_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && smram_q[6]) |-> route_dram_o);

  p_smm_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && smm_active_i && smram_q[3]) |-> route_dram_o);

endmodule

bind legacy_mem_decoder lmd_checker #(.ADDR_W(ADDR_W)) i_lmd_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smm_active_i(smm_active_i),
  .req_addr_i  (req_addr_i),
  .req_we_i    (req_we_i),
  .route_dram_o(route_dram_o),
  .route_bus_o (route_bus_o),
  .route_drop_o(route_drop_o),
  .smram_q     (smram_q)
);

// File: tb/test_legacy_mem_decoder.sv
`timescale 1ns/1ps
module test_legacy_mem_decoder;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        smm = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic        r_dram, r_bus, r_drop;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] pam_m [7];
  logic [7:0] smr_m;

  always #2 clk = ~clk;

  legacy_mem_decoder i_legacy_mem_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .smm_active_i(smm), .req_addr_i(req_addr),
    .req_we_i(req_we), .route_dram_o(r_dram), .route_bus_o(r_bus), .route_drop_o(r_drop)
  );

  // expected code: 1=dram 2=bus 4=drop
  function automatic logic [2:0] expect_route(input logic [31:0] a, input logic w);
    logic [1:0] at;
    int seg;
    if (a < 32'hA0000 || a >= 32'h100000) return 3'b001;          // R9
    if (a < 32'hC0000)                                            // R6 R7
      return (smr_m[6] || (smm && smr_m[3])) ? 3'b001 : 3'b010;
    if (a >= 32'hF0000) at = pam_m[0][5:4];                       // R2
    else begin
      seg = int'((a - 32'hC0000) >> 14);                          // R3
      at  = (seg % 2 == 0) ? pam_m[1 + seg/2][1:0] : pam_m[1 + seg/2][5:4];
    end
    if (!w) return at[0] ? 3'b001 : 3'b010;                       // R4
    if (at[1]) return 3'b001;
    return (at == 2'd1) ? 3'b100 : 3'b010;                        // R5
  endfunction

  task automatic probe(input logic [31:0] a, input logic w, input string tag);
    logic [2:0] got, exp;
    @(negedge clk);
    req_addr = a;
    req_we   = w;
    #1;
    got = {r_drop, r_bus, r_dram};
    exp = expect_route(a, w);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h we=%0b got=%b exp=%b", tag, a, w, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] off, input logic [7:0] d);
    logic [7:0] nv;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off >= 8'h59 && off <= 8'h5F) pam_m[off - 8'h59] = d;
    else if (off == 8'h72) begin
      nv = d;
      if (smr_m[4]) begin nv[4] = 1'b1; nv[6] = 1'b0; end
      else if (d[4]) nv[6] = 1'b0;
      smr_m = nv;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 7; i++) pam_m[i] = 8'h00;
    smr_m = 8'h02;
    rst_ni = 1'b1;
  endtask

  task automatic sweep_segments(input string tag);
    for (int s = 0; s < 13; s++) begin
      logic [31:0] base, last;
      base = (s < 12) ? 32'hC0000 + 32'(s) * 32'h4000 : 32'hF0000;
      last = (s < 12) ? base + 32'h3FFF : 32'hFFFFF;
      probe(base, 1'b0, tag);
      probe(base, 1'b1, tag);
      probe(last, 1'b0, tag);
      probe(last, 1'b1, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset routes everything in the legacy region to the bus
    probe(32'hA0000, 1'b0, "R1");
    probe(32'hBFFFF, 1'b1, "R1");
    sweep_segments("R1");

    // R2 R3 R4 R5 R10: rotating attribute patterns with junk in unused bits
    for (int k = 0; k < 4; k++) begin
      logic [1:0] ab;
      ab = 2'(k);
      cfg_wr(8'h59, {2'(3 - k), ab, 4'(k * 5 + 3)});
      for (int j = 0; j < 6; j++) begin
        logic [1:0] ev, od;
        ev = 2'((2*j + k) & 3);
        od = 2'((2*j + 1 + k) & 3);
        cfg_wr(8'(8'h5A + j), {2'(j + k), od, 2'(k + 1), ev});
      end
      sweep_segments("R3");
    end

    // R10: writes to neighbouring offsets change nothing
    cfg_wr(8'h58, 8'hFF);
    cfg_wr(8'h60, 8'hFF);
    cfg_wr(8'h71, 8'hFF);
    cfg_wr(8'h73, 8'hFF);
    sweep_segments("R10");
    probe(32'hA0000, 1'b0, "R10");

    // R9: just outside both ends
    probe(32'h0, 1'b0, "R9");
    probe(32'h9FFFF, 1'b1, "R9");
    probe(32'h100000, 1'b1, "R9");
    probe(32'hFFFFFFFF, 1'b0, "R9");

    // R6 R7: window control sweep
    for (int c = 0; c < 8; c++) begin
      cfg_wr(8'h72, 8'h02 | (c[0] ? 8'h40 : 8'h00) | (c[1] ? 8'h08 : 8'h00));
      @(negedge clk);
      smm = c[2];
      probe(32'hA0000, 1'b0, c[1] ? "R7" : "R6");
      probe(32'hBFFFF, 1'b1, c[1] ? "R7" : "R6");
    end

    // R7: SMM input takes effect without a clock edge of its own
    cfg_wr(8'h72, 8'h0A);
    @(negedge clk); smm = 1'b1; req_addr = 32'hB0000; req_we = 1'b0; #1;
    checks++;
    if (!(r_dram && !r_bus)) begin
      errors++; $display("FAIL R7 same-cycle smm got dram=%0b exp=1", r_dram);
    end
    smm = 1'b0; #1;
    checks++;
    if (!(r_bus && !r_dram)) begin
      errors++; $display("FAIL R7 same-cycle smm drop got bus=%0b exp=1", r_bus);
    end

    // R8: lock
    smm = 1'b0;
    cfg_wr(8'h72, 8'h52);
    probe(32'hA0000, 1'b0, "R8");
    cfg_wr(8'h72, 8'h42);
    probe(32'hA8000, 1'b1, "R8");
    cfg_wr(8'h72, 8'h0A);
    smm = 1'b1;
    probe(32'hA0000, 1'b0, "R8");
    smm = 1'b0;
    probe(32'hA0000, 1'b0, "R8");
    cfg_wr(8'h72, 8'h42);
    smm = 1'b1;
    probe(32'hA0000, 1'b1, "R8");
    smm = 1'b0;

    // R1 R8: reset clears lock and attributes
    do_reset();
    probe(32'hA0000, 1'b0, "R1");
    probe(32'hC0000, 1'b1, "R1");
    probe(32'hF0000, 1'b0, "R1");
    cfg_wr(8'h72, 8'h42);
    probe(32'hA0000, 1'b0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule